// File: doc/BRIEF.md
# Multi-Channel Interrupt Summary Aggregator

This block collects the interrupt state of up to eight serial channels and exposes it to a host through four byte-wide, read-only summary registers. Every channel provides a pending flag and a vector of raw interrupt sources. The block turns each vector into a compact 3-bit cause code. It then builds two things: a map with one pending bit per channel, and a field that packs the cause codes of all channels side by side. A host that takes the shared interrupt can learn every pending channel and its cause in no more than four byte reads. It does not need to visit each channel's own status register.

A single chip-level interrupt is modelled as an open-drain output. An output-enable asserts whenever any channel is pending. The pin is pulled low only while that enable is active, so several devices can share one host line with an external pull-up. Reading register 0 captures a snapshot of all four bytes, so a multi-byte read sees a consistent view. Reading the registers never clears an interrupt. Each interrupt stays until the channel's own service action removes it.

Top module: `intr_summary_agg`

## Requirements
- R1: After reset, rd_data_o is 0x00, irq_oe_o is 0 and irq_line_o is 1.
- R2: Summary register 0 (address 0) has bit n equal to the pending flag of channel n. Bit 0 belongs to channel 0 and bit 7 to channel 7.
- R3: The cause code of a pending channel comes from its 6-bit source vector, by fixed priority from bit 0 (highest) to bit 5 (lowest). The codes are: bit 0 line status = 3'b001, bit 1 receive data ready = 3'b010, bit 2 receive timeout = 3'b011, bit 3 transmit empty = 3'b100, bit 4 modem status = 3'b101, bit 5 timer event = 3'b111. Code 3'b110 never appears.
- R4: The cause code of channel n sits in bits 3n+2:3n of a 24-bit packed field. Address 1 returns field bits 7:0, address 2 returns bits 15:8 and address 3 returns bits 23:16.
- R5: A channel whose pending flag is 0 shows cause 3'b000. A pending channel with no source bit set also shows 3'b000.
- R6: irq_oe_o is 1 exactly one clock after any channel pending flag is seen high. It is 0 one clock after all flags are seen low. irq_line_o is 0 while irq_oe_o is 1 and 1 otherwise.
- R7: A read issued with rd_en_i in one cycle presents its byte on rd_data_o after the next rising edge. Reading clears nothing, so repeated reads of unchanged inputs return the same byte.
- R8: A read of address 0 refreshes the snapshot from live status. Later reads of addresses 1 to 3 return the snapshot, even if the channel inputs have changed since.
- R9: If no snapshot has been taken since reset, the first read at any address takes one from live status and returns the live byte.
- R10: While rd_en_i is low, rd_data_o holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ch_pend_i | input | NUM_CH | Per-channel interrupt pending flag |
| ch_src_i | input | NUM_CH*6 | Per-channel raw source vector, channel n at bits 6n+5:6n |
| rd_en_i | input | 1 | Host read strobe, one cycle per byte |
| rd_addr_i | input | 2 | Summary register index |
| rd_data_o | output | 8 | Registered read data |
| irq_oe_o | output | 1 | Open-drain enable for the shared interrupt pin |
| irq_line_o | output | 1 | Pin level with pull-up: 0 while enabled, else 1 |

## Verification
On every cycle the assertions check that the interrupt enable follows the registered pending flags one clock later, and that the pin level is low exactly while the enable is active. They also check that no live cause slot holds a code for a channel that is not pending or holds the unused value 3'b110, that the snapshot stays unchanged between refreshing reads, and that an address-0 read returns the pending map. Only the bench scenarios can show a number of other behaviours: that the priority order and the code values are correct, that each channel lands in the right bit position across the byte boundaries, that a snapshot really does hide input changes made between reg-0 and reg-1..3 reads, and that the first read after reset takes the snapshot.

// File: rtl/intr_agg_pkg.sv
package intr_agg_pkg;

   localparam int CAUSE_W = 3;
   localparam int SRC_W   = 6;

   // source vector bit positions, highest priority first
   localparam int SRC_LINE  = 0;
   localparam int SRC_RXRDY = 1;
   localparam int SRC_RXTMO = 2;
   localparam int SRC_TXEMP = 3;
   localparam int SRC_MODEM = 4;
   localparam int SRC_TIMER = 5;

   typedef enum logic [CAUSE_W-1:0] {
      CZ_NONE  = 3'b000,
      CZ_LINE  = 3'b001,
      CZ_RXRDY = 3'b010,
      CZ_RXTMO = 3'b011,
      CZ_TXEMP = 3'b100,
      CZ_MODEM = 3'b101,
      CZ_TIMER = 3'b111
   } cause_e;

endpackage

// File: rtl/intr_cause_enc.sv
module intr_cause_enc
   import intr_agg_pkg::*;
(
   input  logic             pend_i,
   input  logic [SRC_W-1:0] src_i,
   output logic [CAUSE_W-1:0] cause_o
);

   cause_e code;

   always_comb begin
      code = CZ_NONE;
      if (pend_i) begin
         if      (src_i[SRC_LINE])  code = CZ_LINE;
         else if (src_i[SRC_RXRDY]) code = CZ_RXRDY;
         else if (src_i[SRC_RXTMO]) code = CZ_RXTMO;
         else if (src_i[SRC_TXEMP]) code = CZ_TXEMP;
         else if (src_i[SRC_MODEM]) code = CZ_MODEM;
         else if (src_i[SRC_TIMER]) code = CZ_TIMER;
         else                       code = CZ_NONE;
      end
   end

   assign cause_o = code;

endmodule

// File: rtl/intr_live_stage.sv
module intr_live_stage
   import intr_agg_pkg::*;
#(
   parameter int NUM_CH = 8,
   localparam int FIELD_W = NUM_CH * CAUSE_W
)(
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_CH-1:0]  pend_i,
   input  logic [FIELD_W-1:0] cause_i,
   output logic [NUM_CH-1:0]  pend_q_o,
   output logic [FIELD_W-1:0] cause_q_o,
   output logic               irq_oe_o
);

   logic [NUM_CH-1:0]  pend_q;
   logic [FIELD_W-1:0] cause_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q  <= '0;
         cause_q <= '0;
      end else begin
         pend_q  <= pend_i;
         cause_q <= cause_i;
      end
   end

   assign pend_q_o  = pend_q;
   assign cause_q_o = cause_q;
   assign irq_oe_o  = |pend_q;

   // R6: enable follows the sampled flags one clock later
   a_r6_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|pend_i) |=> irq_oe_o);
   a_r6_irq_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(|pend_i) |=> !irq_oe_o);

   for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
      // R5: idle channel carries no cause
      a_r5_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !pend_q[n] |-> (cause_q[n*CAUSE_W +: CAUSE_W] == CZ_NONE));
      // R3: unused code value never reaches the field
      a_r3_no_code6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         cause_q[n*CAUSE_W +: CAUSE_W] != 3'b110);
   end

endmodule

// File: rtl/intr_snap_read.sv
module intr_snap_read #(
   parameter int NUM_CH  = 8,
   parameter int CAUSE_W = 3,
   parameter int DATA_W  = 8,
   parameter int N_REGS  = 4,
   localparam int ADDR_W  = $clog2(N_REGS),
   localparam int FIELD_W = NUM_CH * CAUSE_W,
   localparam int FLAT_W  = N_REGS * DATA_W
)(
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_CH-1:0]  pend_i,
   input  logic [FIELD_W-1:0] cause_i,
   input  logic               rd_en_i,
   input  logic [ADDR_W-1:0]  rd_addr_i,
   output logic [DATA_W-1:0]  rd_data_o
);

   logic [FLAT_W-1:0] live_flat;
   logic [DATA_W-1:0] live_b [N_REGS];
   logic [DATA_W-1:0] snap_b [N_REGS];
   logic              snap_vld;
   logic              capture;
   logic [DATA_W-1:0] rd_q;

   assign live_flat = {(FLAT_W-DATA_W)'(cause_i), DATA_W'(pend_i)};

   for (genvar i = 0; i < N_REGS; i++) begin : g_byte
      assign live_b[i] = live_flat[i*DATA_W +: DATA_W];

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      snap_b[i] <= '0;
         else if (capture) snap_b[i] <= live_b[i];
      end

      // R8: snapshot changes only on a capturing read
      a_r8_snap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !capture |=> $stable(snap_b[i]));
   end

   assign capture = rd_en_i && ((rd_addr_i == '0) || !snap_vld);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         snap_vld <= 1'b0;
         rd_q     <= '0;
      end else if (rd_en_i) begin
         snap_vld <= 1'b1;
         rd_q     <= capture ? live_b[rd_addr_i] : snap_b[rd_addr_i];
      end
   end

   assign rd_data_o = rd_q;

   // R2: an address-0 read returns the pending map seen at the strobe
   a_r2_map_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && rd_addr_i == '0) |=> rd_data_o == DATA_W'($past(pend_i)));
   // R10: idle bus keeps the data
   a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_en_i |=> $stable(rd_data_o));

endmodule

// File: rtl/intr_summary_agg.sv
module intr_summary_agg
   import intr_agg_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int DATA_W = 8,
   parameter int N_REGS = 4,
   localparam int ADDR_W  = $clog2(N_REGS),
   localparam int FIELD_W = NUM_CH * CAUSE_W
)(
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic [NUM_CH-1:0]        ch_pend_i,
   input  logic [NUM_CH*SRC_W-1:0]  ch_src_i,
   input  logic                     rd_en_i,
   input  logic [ADDR_W-1:0]        rd_addr_i,
   output logic [DATA_W-1:0]        rd_data_o,
   output logic                     irq_oe_o,
   output logic                     irq_line_o
);

   if (NUM_CH < 1 || NUM_CH > DATA_W) begin : g_bad_ch
      $error("NUM_CH must lie in 1..DATA_W");
   end
   if (FIELD_W > (N_REGS-1)*DATA_W) begin : g_bad_field
      $error("packed cause field does not fit the summary registers");
   end

   logic [FIELD_W-1:0] cause_live;
   logic [NUM_CH-1:0]  pend_q;
   logic [FIELD_W-1:0] cause_q;
   logic               irq_oe;

   for (genvar n = 0; n < NUM_CH; n++) begin : g_enc
      intr_cause_enc u_enc (
         .pend_i  (ch_pend_i[n]),
         .src_i   (ch_src_i[n*SRC_W +: SRC_W]),
         .cause_o (cause_live[n*CAUSE_W +: CAUSE_W])
      );
   end

   intr_live_stage #(.NUM_CH(NUM_CH)) u_live (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pend_i    (ch_pend_i),
      .cause_i   (cause_live),
      .pend_q_o  (pend_q),
      .cause_q_o (cause_q),
      .irq_oe_o  (irq_oe)
   );

   intr_snap_read #(
      .NUM_CH  (NUM_CH),
      .CAUSE_W (CAUSE_W),
      .DATA_W  (DATA_W),
      .N_REGS  (N_REGS)
   ) u_rd (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pend_i    (pend_q),
      .cause_i   (cause_q),
      .rd_en_i   (rd_en_i),
      .rd_addr_i (rd_addr_i),
      .rd_data_o (rd_data_o)
   );

   assign irq_oe_o   = irq_oe;
   assign irq_line_o = irq_oe ? 1'b0 : 1'b1;

   // R6: pin is low only while the driver is enabled
   a_r6_pin_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_oe_o |-> !irq_line_o);
   a_r6_pin_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_oe_o |-> irq_line_o);

endmodule

// File: tb/intr_summary_agg_tb.sv
module intr_summary_agg_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  pend = '0;
   logic [47:0] src = '0;
   logic        rd_en = 1'b0;
   logic [1:0]  rd_addr = '0;
   logic [7:0]  rd_data;
   logic        irq_oe, irq_line;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   intr_summary_agg u_dut (
      .clk_i(clk), .rst_ni(rst_n), .ch_pend_i(pend), .ch_src_i(src),
      .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .irq_oe_o(irq_oe), .irq_line_o(irq_line));

   function automatic logic [2:0] code_of(input logic p, input logic [5:0] s);
      logic [2:0] tbl [6] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd7};
      if (!p) return 3'd0;
      for (int b = 0; b < 6; b++) if (s[b]) return tbl[b];
      return 3'd0;
   endfunction

   function automatic logic [7:0] exp_byte(input int a, input logic [7:0] p,
                                           input logic [47:0] s);
      logic [23:0] f = '0;
      if (a == 0) return p;
      for (int c = 0; c < 8; c++) f[c*3 +: 3] = code_of(p[c], s[c*6 +: 6]);
      return f[(a-1)*8 +: 8];
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [7:0] p, input logic [47:0] s);
      @(negedge clk); pend = p; src = s;
      @(negedge clk); @(negedge clk);
   endtask

   task automatic rd(input int a, output logic [7:0] d);
      @(negedge clk); rd_en = 1'b1; rd_addr = 2'(a);
      @(negedge clk); rd_en = 1'b0; d = rd_data;
   endtask

   task automatic rd_all(input string req, input logic [7:0] p, input logic [47:0] s);
      logic [7:0] d;
      for (int a = 0; a < 4; a++) begin
         rd(a, d);
         chk(req, d, exp_byte(a, p, s));
      end
   endtask

   task automatic chk_irq(input logic [7:0] p);
      chk("R6 oe", {7'd0, irq_oe}, {7'd0, |p});
      chk("R6 line", {7'd0, irq_line}, {7'd0, ~|p});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0]  d, d2, p0;
      logic [47:0] s0;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 data", rd_data, 8'h00);
      chk("R1 oe", {7'd0, irq_oe}, 8'h00);
      chk("R1 line", {7'd0, irq_line}, 8'h01);
      rst_n = 1'b1;

      // R9 first read after reset captures live status
      p0 = 8'h05; s0 = 48'h0; s0[5:0] = 6'b001000; s0[17:12] = 6'b100000;
      drive(p0, s0);
      rd(1, d); chk("R9 first read live", d, exp_byte(1, p0, s0));
      drive(8'hF0, {48{1'b1}});
      rd(2, d); chk("R9 snapshot kept", d, exp_byte(2, p0, s0));
      rd(0, d); chk("R8 reg0 refresh", d, 8'hF0);
      rd(3, d); chk("R8 refreshed field", d, exp_byte(3, 8'hF0, {48{1'b1}}));

      // R3 priority: bits at and above k set, so bit k wins
      for (int k = 0; k < 6; k++) begin
         logic [5:0] v = 6'h3f << k;
         drive(8'h01, {42'd0, v});
         rd(0, d); rd(1, d);
         chk($sformatf("R3 priority bit %0d", k), {5'd0, d[2:0]},
             {5'd0, code_of(1'b1, v)});
      end

      // R4 each channel alone with timer-only source
      for (int c = 0; c < 8; c++) begin
         logic [47:0] s = '0;
         s[c*6 + 5] = 1'b1;
         drive(8'(1 << c), s);
         rd_all("R4 position", 8'(1 << c), s);
      end

      // R5 idle channel with sources, pending channel without
      drive(8'h02, {48{1'b1}} & ~(48'h3f << 6));
      rd_all("R5 zero codes", 8'h02, {48{1'b1}} & ~(48'h3f << 6));

      // R7 repeat reads and R10 hold
      drive(8'hA5, 48'h123456789ABC);
      rd(0, d); rd(0, d2);
      chk("R7 repeat read", d2, d);
      chk("R7 value", d, 8'hA5);
      repeat (4) @(negedge clk);
      chk("R10 hold", rd_data, d);

      // R8 snapshot hides input changes
      drive(8'h3C, 48'hFEDCBA987654);
      rd(0, d);
      drive(8'hC3, 48'h0123456789AB);
      for (int a = 1; a < 4; a++) begin
         rd(a, d);
         chk("R8 snapshot", d, exp_byte(a, 8'h3C, 48'hFEDCBA987654));
      end

      // random mix
      for (int it = 0; it < 60; it++) begin
         logic [7:0]  p = 8'($urandom);
         logic [47:0] s = {16'($urandom), 32'($urandom)};
         if (it % 7 == 0) p = 8'h00;
         drive(p, s);
         chk_irq(p);
         rd_all("R2/R4 random", p, s);
      end

      // R6 deassert
      drive(8'h00, 48'h0);
      chk_irq(8'h00);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule